// File: doc/BRIEF.md
# Read-to-Lock Hardware Semaphore Bank

This block holds a set of single-bit hardware locks that several bus masters share, for example host functions and a management microcontroller. Each lock sits behind its own 32-bit register word. A master takes a lock by reading its word. If the read returns 0, the lock was free and now belongs to that master. If it returns 1, the lock was already held, and the master must try again with a later access. A held lock is freed by writing a value with bit 0 set. A write with bit 0 clear does nothing.

The register port has independent read and write channels, so a read and a write can arrive in the same cycle. Read data is registered and shows up one cycle after the read request, together with a valid strobe. The word just past the last lock is a debug view: reading it returns all lock bits as a vector and changes no state.

Top module: `hw_sem_bank`

## Requirements
- R1: After a synchronous active-low reset, every lock is free (0), and `rd_valid` and `rd_data` are 0.
- R2: A read of a free lock word (word address i < NUM_SEM) returns 0 in the cycle after the request, with `rd_valid` high, and leaves that lock taken (1).
- R3: A read of a taken lock word returns 1 and leaves the lock taken.
- R4: A write with `wr_data[0]`=1 to a taken lock frees it.
- R5: A write with `wr_data[0]`=0 to a taken lock leaves it taken, whatever bits 31:1 hold.
- R6: Any write to a free lock leaves it free.
- R7: For lock words, `rd_data` bits 31:1 are always 0.
- R8: When a read and a write target the same lock in the same cycle, the read returns the value held before the cycle and takes the lock, and the write is then applied to that result.
- R9: Reading word address NUM_SEM returns the lock vector, with bit i equal to lock i. This read has no side effect, and writes to that address are ignored.
- R10: Reads of addresses above NUM_SEM return 0 with `rd_valid` high and change no lock. Writes to those addresses change no lock.
- R11: An access to one lock never changes any other lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request for this cycle |
| rd_addr | input | ADDR_W (5) | Word address of the read |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | ADDR_W (5) | Word address of the write |
| wr_data | input | 32 | Write data; only bit 0 matters |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a read result |

## Verification
A lock acquisition (the read side) and a lock release (the write side) can hit the same lock in one cycle. The bench provokes this by driving both channels to one address on the same clock edge. It covers the lock held and free before the edge, and bit 0 of the write both set and clear. It judges the returned read value against the state before the edge, and the resulting lock bit, read back through the debug word, against "take first, then apply the write". A second case pairs a read of one lock with a release of a different lock in the same cycle, to show that the two locks do not interfere.

// File: rtl/hw_sem_pkg.sv
// Package: shared constants for the semaphore bank.
// Assumes: register words are 32 bits wide.
package hw_sem_pkg;
    localparam int unsigned DATA_W = 32;
endpackage

// File: rtl/hw_sem_addr_decode.sv
// Module: hw_sem_addr_decode
// Turns one access channel (enable plus word address) into a one-hot
// lock select and a flag for the debug view word.
// Assumes: lock words are at addresses 0..NUM_SEM-1 and the debug word
// is at NUM_SEM. Higher addresses select nothing.
module hw_sem_addr_decode #(
    parameter int unsigned NUM_SEM = 16,
    parameter int unsigned ADDR_W  = $clog2(NUM_SEM + 1)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_SEM-1:0] sem_hit,
    output logic              view_hit,
    output logic              out_of_range
);
    // Compare the address against every lock word.
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_hit
        assign sem_hit[i] = en && (addr == ADDR_W'(i));
    end

    // Select the debug word, or flag an address past it.
    always_comb begin
        view_hit     = en && (addr == ADDR_W'(NUM_SEM));
        out_of_range = en && (addr >  ADDR_W'(NUM_SEM));
    end
endmodule

// File: rtl/hw_sem_lock_cell.sv
// Module: hw_sem_lock_cell
// One lock bit. A read selects it and sets it; after that, a write with
// release=1 clears it. Both can arrive in one cycle.
// Assumes: synchronous active-low reset to the free state.
module hw_sem_lock_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic release_bit,
    output logic locked
);
    logic lock_q;
    logic after_read;

    // Lock state once the read side has taken effect.
    always_comb begin
        after_read = lock_q | rd_hit;
    end

    // Apply the write after the read and store the result.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= after_read & ~(wr_hit & release_bit);
    end

    assign locked = lock_q;

    // R2
    take_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !lock_q && !(wr_hit && release_bit)) |=> lock_q);
    // R3
    held_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && lock_q && !(wr_hit && release_bit)) |=> lock_q);
    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && release_bit) |=> !lock_q);
    // R5
    keep_on_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_hit && !release_bit) |=> lock_q);
    // R6
    free_stays_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !rd_hit) |=> !lock_q);
endmodule

// File: rtl/hw_sem_rd_mux.sv
// Module: hw_sem_rd_mux
// Builds the read word from the lock bits as they were before this cycle.
// Assumes: NUM_SEM <= DATA_W and at most one select is active.
module hw_sem_rd_mux
    import hw_sem_pkg::*;
#(
    parameter int unsigned NUM_SEM = 16
) (
    input  logic [NUM_SEM-1:0] sem_hit,
    input  logic              view_hit,
    input  logic [NUM_SEM-1:0] lock_vec,
    output logic [DATA_W-1:0] data
);
    // Pick either one lock bit in bit 0 or the whole vector.
    always_comb begin
        data = '0;
        if (view_hit) data[NUM_SEM-1:0] = lock_vec;
        else          data[0]           = |(sem_hit & lock_vec);
    end
endmodule

// File: rtl/hw_sem_bank.sv
// Module: hw_sem_bank (top)
// A bank of read-to-lock semaphores on separate read and write channels.
// Read data is registered and is valid one cycle after the request.
// Assumes: NUM_SEM <= 32, and only bit 0 of the write data carries meaning.
module hw_sem_bank
    import hw_sem_pkg::*;
#(
    parameter int unsigned NUM_SEM = 16,
    parameter int unsigned ADDR_W  = $clog2(NUM_SEM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [NUM_SEM-1:0] rd_sem_hit;
    logic [NUM_SEM-1:0] wr_sem_hit;
    logic [NUM_SEM-1:0] lock_vec;
    logic               rd_view_hit;
    logic               rd_oor;
    logic               wr_view_hit;
    logic               wr_oor;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  rd_data_q;
    logic               rd_valid_q;

    hw_sem_addr_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) i_rd_dec (
        .en(rd_en), .addr(rd_addr), .sem_hit(rd_sem_hit),
        .view_hit(rd_view_hit), .out_of_range(rd_oor)
    );

    hw_sem_addr_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) i_wr_dec (
        .en(wr_en), .addr(wr_addr), .sem_hit(wr_sem_hit),
        .view_hit(wr_view_hit), .out_of_range(wr_oor)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
        hw_sem_lock_cell i_cell (
            .clk(clk), .rst_n(rst_n),
            .rd_hit(rd_sem_hit[i]), .wr_hit(wr_sem_hit[i]),
            .release_bit(wr_data[0]), .locked(lock_vec[i])
        );
    end

    hw_sem_rd_mux #(.NUM_SEM(NUM_SEM)) i_mux (
        .sem_hit(rd_sem_hit), .view_hit(rd_view_hit),
        .lock_vec(lock_vec), .data(rd_word)
    );

    // Register the read word and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_data_q  <= rd_en ? rd_word : '0;
            rd_valid_q <= rd_en;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // R7
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_view_hit) |=> (rd_data[DATA_W-1:1] == '0));
    // R9
    view_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_view_hit || wr_view_hit) && !(|rd_sem_hit) && !(|wr_sem_hit)) |=> $stable(lock_vec));
    // R10
    oor_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_oor || !rd_en) && (wr_oor || !wr_en)) |=> ($countones(lock_vec) <= $countones($past(lock_vec))));
    // R10
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oor |=> (rd_valid && rd_data == '0));
    // R11
    single_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($countones(lock_vec ^ $past(lock_vec)) <= 1));
endmodule

// File: tb/test_hw_sem_bank.sv
`timescale 1ns/1ps
module test_hw_sem_bank;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hw_sem_bank #(.NUM_SEM(NS)) i_hw_sem_bank (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, sample at the next falling edge.
    task automatic access(input logic rd, input logic [4:0] ra, input logic wr,
                          input logic [4:0] wa, input logic [31:0] wd,
                          output logic [31:0] rdat, output logic rv);
        rd_en = rd; rd_addr = ra; wr_en = wr; wr_addr = wa; wr_data = wd;
        @(negedge clk);
        rdat = rd_data; rv = rd_valid;
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        logic v;
        access(1'b1, a, 1'b0, '0, '0, d, v);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] x; logic v;
        access(1'b0, '0, 1'b1, a, d, x, v);
    endtask

    task automatic view(output logic [31:0] d);
        rd(5'(NS), d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        view(d);
        check("R1 all free", d, 32'h0);
    endtask

    task automatic t_take;
        logic [31:0] d; logic v;
        access(1'b1, 5'd3, 1'b0, '0, '0, d, v);
        check("R2 read free", d, 32'h0);
        check("R2 valid", {31'b0, v}, 32'h1);
        view(d);
        check("R2 now taken", d, 32'h8);
        rd(5'd3, d);
        check("R3 read taken", d, 32'h1);
        view(d);
        check("R3 stays taken", d, 32'h8);
    endtask

    task automatic t_release;
        logic [31:0] d;
        wr(5'd3, 32'h0);
        view(d);
        check("R5 write 0 keeps", d, 32'h8);
        wr(5'd3, 32'hFFFF_FFFE);
        view(d);
        check("R5 upper bits ignored", d, 32'h8);
        wr(5'd3, 32'h1);
        view(d);
        check("R4 release", d, 32'h0);
        wr(5'd3, 32'h1);
        wr(5'd6, 32'hFFFF_FFFF);
        view(d);
        check("R6 write to free", d, 32'h0);
    endtask

    task automatic t_upper;
        logic [31:0] d;
        rd(5'd15, d);
        check("R7 free word", d, 32'h0);
        rd(5'd15, d);
        check("R7 taken word", d, 32'h1);
        wr(5'd15, 32'h1);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d; logic v;
        access(1'b1, 5'd5, 1'b1, 5'd5, 32'h1, d, v);
        check("R8 free rd+rel data", d, 32'h0);
        view(d);
        check("R8 free rd+rel ends free", d, 32'h0);
        access(1'b1, 5'd5, 1'b1, 5'd5, 32'h0, d, v);
        check("R8 free rd+wr0 data", d, 32'h0);
        view(d);
        check("R8 free rd+wr0 ends taken", d, 32'h20);
        access(1'b1, 5'd5, 1'b1, 5'd5, 32'h1, d, v);
        check("R8 taken rd+rel data", d, 32'h1);
        view(d);
        check("R8 taken rd+rel ends free", d, 32'h0);
        rd(5'd7, d);
        access(1'b1, 5'd2, 1'b1, 5'd7, 32'h1, d, v);
        check("R11 other lock read", d, 32'h0);
        view(d);
        check("R11 independent", d, 32'h4);
        wr(5'd2, 32'h1);
    endtask

    task automatic t_view;
        logic [31:0] d;
        rd(5'd0, d);
        rd(5'd9, d);
        view(d);
        check("R9 vector", d, 32'h201);
        view(d);
        check("R9 no side effect", d, 32'h201);
        wr(5'(NS), 32'hFFFF_FFFF);
        view(d);
        check("R9 write ignored", d, 32'h201);
        rd(5'd0, d);
        check("R9 lock 0 still held", d, 32'h1);
    endtask

    task automatic t_oor;
        logic [31:0] d; logic v;
        access(1'b1, 5'd17, 1'b0, '0, '0, d, v);
        check("R10 data", d, 32'h0);
        check("R10 valid", {31'b0, v}, 32'h1);
        access(1'b1, 5'd31, 1'b1, 5'd20, 32'h1, d, v);
        check("R10 data hi", d, 32'h0);
        view(d);
        check("R10 no change", d, 32'h201);
    endtask

    initial begin : watchdog
        #(5.0 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_take();
        t_release();
        t_upper();
        t_same_cycle();
        t_view();
        t_oor();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule